// File: doc/BRIEF.md
# Parallel Video Capture Front End

This block sits at the input pins of a parallel camera port. It runs on the camera's pixel clock and samples a 16-bit data bus together with separate vertical and horizontal sync lines on every rising edge. A configured edge of vertical sync opens a frame, and a configured edge of horizontal sync opens a line. After a programmable number of blanking samples, each sample up to the next sync edge counts as an active pixel.

Active pixels leave the block as a stream. Each pixel carries a valid strobe and start-of-frame, start-of-line and end-of-line markers. The block can take grayscale data in one of three widths, or 4:2:2 luma/chroma data carried on two byte lanes. The block measures every frame it receives. When the next frame opens, it reports that frame's width and height and raises a flag if either one is not legal.

The field and data-enable pins are accepted so that a board can wire them up, but nothing inside the block uses them. Configuration is expected to be static while video flows, and is changed under reset.

Top module: `vcap_top`

## Requirements
- R1: While `rst` is high, and on the first clock after it, all outputs are zero, including the measured width, height and error flag.
- R2: A frame opens on the vertical sync edge selected by `cfg_vs_fall` (0 = rising, 1 = falling). The opposite transition does nothing. Horizontal sync edges seen before the first frame produce no pixels.
- R3: A line opens on the horizontal sync edge selected by `cfg_hs_fall` (0 = rising, 1 = falling). The opposite transition does nothing.
- R4: The sample that carries a line-opening edge is blanking. The next `cfg_hblank` samples are also blanking. Every later sample is an active pixel until the next vertical or horizontal sync edge.
- R5: Grayscale encodings of `cfg_fmt`: 0 passes bus bits 7:0, 1 passes bits 13:0, and 2 passes bits 15:0 on `pix_gray`. Unused upper bits read as zero. In these modes `pix_luma`, `pix_chroma` and `pix_cr` are zero.
- R6: With `cfg_fmt` = 3, `pix_luma` takes bus bits 15:8 and `pix_chroma` takes bus bits 7:0. `pix_cr` is 0 on even pixel positions in a line (blue difference) and 1 on odd ones. `pix_gray` is zero.
- R7: Every active pixel appears once with `pix_valid`, in the order it arrived. `pix_sof` marks the first pixel of a frame, `pix_sol` marks the first pixel of each line, and `pix_eol` marks the last pixel of each line.
- R8: When a frame is closed by the next selected vertical sync edge, `frm_done` pulses for one cycle. At the same time `frm_height` takes the number of lines that held at least one pixel, and `frm_width` takes the pixel count of the frame's last such line.
- R9: `frm_dim_err` is set when a frame closes if the width or height is zero, is not a multiple of 8, or is above 4112 × 3040. Otherwise it is cleared. It changes only together with `frm_done`.
- R10: `vid_field` and `vid_dvalid` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Data format: 0/1/2 grayscale 8/14/16 bit, 3 luma/chroma 4:2:2 |
| cfg_vs_fall | input | 1 | Frame opens on falling vertical sync when 1 |
| cfg_hs_fall | input | 1 | Line opens on falling horizontal sync when 1 |
| cfg_hblank | input | 8 | Blanking samples after the line-opening sample |
| vid_data | input | 16 | Parallel pixel bus |
| vid_vsync | input | 1 | Vertical sync |
| vid_hsync | input | 1 | Horizontal sync |
| vid_field | input | 1 | Field pin, unused |
| vid_dvalid | input | 1 | Data-enable pin, unused |
| pix_valid | output | 1 | Output pixel strobe |
| pix_sof | output | 1 | First pixel of frame |
| pix_sol | output | 1 | First pixel of line |
| pix_eol | output | 1 | Last pixel of line |
| pix_gray | output | 16 | Grayscale value |
| pix_luma | output | 8 | Luma byte |
| pix_chroma | output | 8 | Chroma byte |
| pix_cr | output | 1 | Chroma phase: 0 blue, 1 red difference |
| frm_done | output | 1 | One-cycle pulse when a frame closes |
| frm_width | output | 13 | Measured width of the last closed frame |
| frm_height | output | 13 | Measured height of the last closed frame |
| frm_dim_err | output | 1 | Dimension error of the last closed frame |

## Verification
The bench drives whole frames under each sync polarity, each blanking length (including zero) and each data format. It fills blanking samples with all-ones data and toggles the field and data-enable pins at random. This way, a design that counted a blanking sample, used an ignored pin, or let stray high bus bits through would produce a wrong pixel count or wrong data. The dimension limits are tested on both sides: a width of 4112 against 4120, a height of 3040 against 3048, and widths and heights that are not multiples of 8. A design that compared with the wrong bound, or checked alignment on the wrong bits, would give the wrong error flag. Horizontal sync pulses are also sent before any vertical sync; a design that opened lines outside a frame would emit pixels there. Reset is asserted in the middle of a line after earlier frames have been measured; a design that kept its held pixel or its old measurements would show them at the outputs.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    FMT_GRAY8  = 2'd0,
    FMT_GRAY14 = 2'd1,
    FMT_GRAY16 = 2'd2,
    FMT_YCC422 = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [BUS_W-1:0]  gray;
    logic [BYTE_W-1:0] luma;
    logic [BYTE_W-1:0] chroma;
    logic              cr;
  } pix_t;

endpackage

// File: rtl/vcap_sync_edge.sv
module vcap_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  input  logic fall_sel,
  output logic edge_hit
);

  logic smp_q;
  logic smp_qq;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= 1'b0;
      smp_qq <= 1'b0;
    end else begin
      smp_q  <= sync_in;
      smp_qq <= smp_q;
    end
  end

  // compare the current sample against the previous one
  assign edge_hit = fall_sel ? (~smp_q & smp_qq) : (smp_q & ~smp_qq);

endmodule

// File: rtl/vcap_fmt.sv
module vcap_fmt
  import vcap_pkg::*;
(
  input  logic [BUS_W-1:0] raw,
  input  fmt_e             mode,
  input  logic             col_odd,
  output pix_t             pix
);

  always_comb begin
    pix = '0;
    unique case (mode)
      FMT_GRAY8:  pix.gray = {{(BUS_W-8){1'b0}},  raw[7:0]};
      FMT_GRAY14: pix.gray = {{(BUS_W-14){1'b0}}, raw[13:0]};
      FMT_GRAY16: pix.gray = raw;
      FMT_YCC422: begin
        pix.luma   = raw[BUS_W-1 -: BYTE_W];
        pix.chroma = raw[BYTE_W-1:0];
        pix.cr     = col_odd;
      end
    endcase
  end

endmodule

// File: rtl/vcap_line_trk.sv
module vcap_line_trk #(
  parameter int CNT_W      = 13,
  parameter int BLANK_W    = 8,
  parameter int MAX_W      = 4112,
  parameter int MAX_H      = 3040,
  parameter int ALIGN_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hs_edge,
  input  logic               vs_edge,
  input  logic [BLANK_W-1:0] cfg_hblank,
  output logic               pix_ok,
  output logic               pix_sol,
  output logic               pix_sof,
  output logic               pix_odd,
  output logic               line_end,
  output logic               frame_done,
  output logic [CNT_W-1:0]   meas_w,
  output logic [CNT_W-1:0]   meas_h,
  output logic               dim_err
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM_W   = CNT_W'(MAX_W);
  localparam logic [CNT_W-1:0] LIM_H   = CNT_W'(MAX_H);

  logic               in_frame;
  logic               active;
  logic               sof_arm;
  logic [BLANK_W-1:0] blank_cnt;
  logic [CNT_W-1:0]   pix_cnt;
  logic [CNT_W-1:0]   line_cnt;
  logic [CNT_W-1:0]   last_w;

  logic               any_edge;
  logic               line_has;
  logic [CNT_W-1:0]   cur_w;
  logic [CNT_W-1:0]   cur_h;
  logic               cur_bad;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  assign any_edge = hs_edge | vs_edge;
  assign pix_ok   = active & ~any_edge;
  assign pix_sol  = pix_ok & (pix_cnt == '0);
  assign pix_sof  = pix_ok & sof_arm;
  assign pix_odd  = pix_cnt[0];
  assign line_end = any_edge;

  assign line_has = (pix_cnt != '0);
  assign cur_w    = line_has ? pix_cnt : last_w;
  assign cur_h    = line_has ? sat_inc(line_cnt) : line_cnt;
  assign cur_bad  = (cur_w == '0) || (cur_h == '0) ||
                    (cur_w[ALIGN_LOG2-1:0] != '0) ||
                    (cur_h[ALIGN_LOG2-1:0] != '0) ||
                    (cur_w > LIM_W) || (cur_h > LIM_H);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame   <= 1'b0;
      active     <= 1'b0;
      sof_arm    <= 1'b0;
      blank_cnt  <= '0;
      pix_cnt    <= '0;
      line_cnt   <= '0;
      last_w     <= '0;
      frame_done <= 1'b0;
      meas_w     <= '0;
      meas_h     <= '0;
      dim_err    <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (any_edge) begin
        if (line_has) begin
          line_cnt <= sat_inc(line_cnt);
          last_w   <= pix_cnt;
        end
        pix_cnt   <= '0;
        active    <= 1'b0;
        blank_cnt <= '0;
        if (vs_edge) begin
          if (in_frame) begin
            frame_done <= 1'b1;
            meas_w     <= cur_w;
            meas_h     <= cur_h;
            dim_err    <= cur_bad;
          end
          in_frame <= 1'b1;
          sof_arm  <= 1'b1;
          line_cnt <= '0;
          last_w   <= '0;
        end
        if (hs_edge && (in_frame || vs_edge)) begin
          if (cfg_hblank == '0) active    <= 1'b1;
          else                  blank_cnt <= cfg_hblank;
        end
      end else begin
        if (blank_cnt != '0) begin
          blank_cnt <= blank_cnt - 1'b1;
          if (blank_cnt == BLANK_W'(1)) active <= 1'b1;
        end
        if (active) begin
          pix_cnt <= sat_inc(pix_cnt);
          sof_arm <= 1'b0;
        end
      end
    end
  end

  AST_BLANK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(active && (blank_cnt != '0))); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R8

endmodule

// File: rtl/vcap_top.sv
module vcap_top
  import vcap_pkg::*;
#(
  parameter int CNT_W      = 13,
  parameter int BLANK_W    = 8,
  parameter int MAX_W      = 4112,
  parameter int MAX_H      = 3040,
  parameter int ALIGN_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cfg_fmt,
  input  logic               cfg_vs_fall,
  input  logic               cfg_hs_fall,
  input  logic [BLANK_W-1:0] cfg_hblank,
  input  logic [15:0]        vid_data,
  input  logic               vid_vsync,
  input  logic               vid_hsync,
  input  logic               vid_field,
  input  logic               vid_dvalid,
  output logic               pix_valid,
  output logic               pix_sof,
  output logic               pix_sol,
  output logic               pix_eol,
  output logic [15:0]        pix_gray,
  output logic [7:0]         pix_luma,
  output logic [7:0]         pix_chroma,
  output logic               pix_cr,
  output logic               frm_done,
  output logic [CNT_W-1:0]   frm_width,
  output logic [CNT_W-1:0]   frm_height,
  output logic               frm_dim_err
);

  localparam int N_SYNC = 2;
  localparam int IDX_VS = 1;
  localparam int IDX_HS = 0;

  // field and data-enable pins are intentionally not used
  logic unused_side;
  assign unused_side = vid_field ^ vid_dvalid;

  logic [BUS_W-1:0]  data_q;
  logic [N_SYNC-1:0] sync_raw;
  logic [N_SYNC-1:0] sync_fall;
  logic [N_SYNC-1:0] sync_hit;

  assign sync_raw  = {vid_vsync, vid_hsync};
  assign sync_fall = {cfg_vs_fall, cfg_hs_fall};

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= vid_data;
  end

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    vcap_sync_edge u_edge (
      .clk      (clk),
      .rst      (rst),
      .sync_in  (sync_raw[g]),
      .fall_sel (sync_fall[g]),
      .edge_hit (sync_hit[g])
    );
  end

  logic pix_ok, t_sol, t_sof, t_odd, line_end;

  vcap_line_trk #(
    .CNT_W      (CNT_W),
    .BLANK_W    (BLANK_W),
    .MAX_W      (MAX_W),
    .MAX_H      (MAX_H),
    .ALIGN_LOG2 (ALIGN_LOG2)
  ) u_trk (
    .clk        (clk),
    .rst        (rst),
    .hs_edge    (sync_hit[IDX_HS]),
    .vs_edge    (sync_hit[IDX_VS]),
    .cfg_hblank (cfg_hblank),
    .pix_ok     (pix_ok),
    .pix_sol    (t_sol),
    .pix_sof    (t_sof),
    .pix_odd    (t_odd),
    .line_end   (line_end),
    .frame_done (frm_done),
    .meas_w     (frm_width),
    .meas_h     (frm_height),
    .dim_err    (frm_dim_err)
  );

  pix_t fmt_pix;

  vcap_fmt u_fmt (
    .raw     (data_q),
    .mode    (fmt_e'(cfg_fmt)),
    .col_odd (t_odd),
    .pix     (fmt_pix)
  );

  // one-pixel hold so the last pixel of a line can carry its end marker
  pix_t hold_pix;
  logic hold_v, hold_sof, hold_sol;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v     <= 1'b0;
      hold_sof   <= 1'b0;
      hold_sol   <= 1'b0;
      hold_pix   <= '0;
      pix_valid  <= 1'b0;
      pix_sof    <= 1'b0;
      pix_sol    <= 1'b0;
      pix_eol    <= 1'b0;
      pix_gray   <= '0;
      pix_luma   <= '0;
      pix_chroma <= '0;
      pix_cr     <= 1'b0;
    end else begin
      pix_valid <= 1'b0;
      pix_sof   <= 1'b0;
      pix_sol   <= 1'b0;
      pix_eol   <= 1'b0;
      if (hold_v && (pix_ok || line_end)) begin
        pix_valid  <= 1'b1;
        pix_sof    <= hold_sof;
        pix_sol    <= hold_sol;
        pix_eol    <= line_end;
        pix_gray   <= hold_pix.gray;
        pix_luma   <= hold_pix.luma;
        pix_chroma <= hold_pix.chroma;
        pix_cr     <= hold_pix.cr;
      end
      if (pix_ok) begin
        hold_v   <= 1'b1;
        hold_pix <= fmt_pix;
        hold_sof <= t_sof;
        hold_sol <= t_sol;
      end else if (line_end) begin
        hold_v <= 1'b0;
      end
    end
  end

  AST_SOF_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    pix_sof |-> pix_valid); // R7

  AST_EOL_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    pix_eol |-> pix_valid); // R7

  AST_GRAY8_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && cfg_fmt == 2'd0) |-> (pix_gray[15:8] == '0)); // R5

  AST_LANES_GRAY_ONLY: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && cfg_fmt != 2'd3) |-> (pix_luma == '0 && pix_chroma == '0 && !pix_cr)); // R6

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(frm_dim_err) |-> frm_done); // R9

endmodule

// File: tb/test_vcap_top.sv
module test_vcap_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_fmt = '0;
  logic        cfg_vs_fall = 1'b0;
  logic        cfg_hs_fall = 1'b0;
  logic [7:0]  cfg_hblank = '0;
  logic [15:0] vid_data = '0;
  logic        vid_vsync = 1'b0;
  logic        vid_hsync = 1'b0;
  logic        vid_field = 1'b0;
  logic        vid_dvalid = 1'b0;
  logic        pix_valid, pix_sof, pix_sol, pix_eol, pix_cr;
  logic [15:0] pix_gray;
  logic [7:0]  pix_luma, pix_chroma;
  logic        frm_done, frm_dim_err;
  logic [12:0] frm_width, frm_height;

  always #4 clk = ~clk;

  vcap_top i_vcap_top (
    .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_vs_fall(cfg_vs_fall),
    .cfg_hs_fall(cfg_hs_fall), .cfg_hblank(cfg_hblank), .vid_data(vid_data),
    .vid_vsync(vid_vsync), .vid_hsync(vid_hsync), .vid_field(vid_field),
    .vid_dvalid(vid_dvalid), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_sol(pix_sol), .pix_eol(pix_eol), .pix_gray(pix_gray),
    .pix_luma(pix_luma), .pix_chroma(pix_chroma), .pix_cr(pix_cr),
    .frm_done(frm_done), .frm_width(frm_width), .frm_height(frm_height),
    .frm_dim_err(frm_dim_err)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        vsf;
    logic        hsf;
    logic [7:0]  blank;
    logic [12:0] w;
    logic [12:0] h;
    logic        err;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'd0, 1'b0, 1'b0, 8'd2, 13'd16,   13'd8,    1'b0},
    '{2'd1, 1'b1, 1'b0, 8'd0, 13'd8,    13'd16,   1'b0},
    '{2'd2, 1'b0, 1'b1, 8'd5, 13'd24,   13'd8,    1'b0},
    '{2'd3, 1'b1, 1'b1, 8'd3, 13'd16,   13'd8,    1'b0},
    '{2'd0, 1'b0, 1'b0, 8'd1, 13'd12,   13'd8,    1'b1},
    '{2'd2, 1'b0, 1'b0, 8'd1, 13'd8,    13'd12,   1'b1},
    '{2'd0, 1'b0, 1'b0, 8'd0, 13'd4112, 13'd8,    1'b0},
    '{2'd0, 1'b0, 1'b0, 8'd0, 13'd4120, 13'd8,    1'b1},
    '{2'd0, 1'b0, 1'b0, 8'd1, 13'd8,    13'd3040, 1'b0},
    '{2'd0, 1'b1, 1'b0, 8'd1, 13'd8,    13'd3048, 1'b1}
  };

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;

  task automatic tick();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    vid_field  = lfsr[0];
    vid_dvalid = lfsr[5];
    @(negedge clk);
  endtask

  function automatic logic [15:0] raw_of(input int l, input int c);
    return {8'(l) ^ 8'hA5, 8'(c)};
  endfunction

  // output monitor
  int mon_cnt, mon_data_err, mon_flag_err, mon_done, exp_w;
  logic [1:0] exp_mode;
  longint fd_act, fd_exp, ff_act, ff_exp;

  always @(negedge clk) begin : mon
    int l, c;
    logic [15:0] r;
    logic [32:0] ed, ad;
    logic [2:0] ef, af;
    if (!rst) begin
      if (frm_done) mon_done++;
      if (pix_valid) begin
        l = mon_cnt / exp_w;
        c = mon_cnt % exp_w;
        r = raw_of(l, c);
        case (exp_mode)
          2'd0: ed = {16'(r[7:0]), 8'h0, 8'h0, 1'b0};
          2'd1: ed = {16'(r[13:0]), 8'h0, 8'h0, 1'b0};
          2'd2: ed = {r, 8'h0, 8'h0, 1'b0};
          default: ed = {16'h0, r[15:8], r[7:0], 1'(c % 2)};
        endcase
        ad = {pix_gray, pix_luma, pix_chroma, pix_cr};
        ef = {mon_cnt == 0, c == 0, c == exp_w - 1};
        af = {pix_sof, pix_sol, pix_eol};
        if (ad !== ed) begin
          if (mon_data_err == 0) begin fd_act = longint'(ad); fd_exp = longint'(ed); end
          mon_data_err++;
        end
        if (af !== ef) begin
          if (mon_flag_err == 0) begin ff_act = longint'(af); ff_exp = longint'(ef); end
          mon_flag_err++;
        end
        mon_cnt++;
      end
    end
  end

  task automatic reset_cfg(input vec_t v);
    rst = 1'b1;
    cfg_fmt = v.mode; cfg_vs_fall = v.vsf; cfg_hs_fall = v.hsf; cfg_hblank = v.blank;
    vid_vsync = v.vsf; vid_hsync = v.hsf; vid_data = 16'hFFFF;
    repeat (3) tick();
    rst = 1'b0;
    repeat (2) tick();
    mon_cnt = 0; mon_data_err = 0; mon_flag_err = 0; mon_done = 0;
    exp_w = int'(v.w); exp_mode = v.mode;
  endtask

  task automatic vs_pulse(input logic vsf);
    vid_vsync = ~vsf; vid_data = 16'hFFFF; tick();
    vid_vsync = vsf;
  endtask

  task automatic send_line(input int l, input vec_t v);
    vid_hsync = ~v.hsf; vid_data = 16'hFFFF; tick();
    vid_hsync = v.hsf;
    for (int b = 0; b < int'(v.blank); b++) tick();
    for (int c = 0; c < int'(v.w); c++) begin
      vid_data = raw_of(l, c); tick();
    end
  endtask

  initial begin
    vec_t v;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      reset_cfg(v);
      vs_pulse(v.vsf);
      for (int l = 0; l < int'(v.h); l++) send_line(l, v);
      vs_pulse(v.vsf);
      repeat (4) tick();
      chk(mon_done == 1, "R2 one frame closed on selected vsync edge", mon_done, 1);
      chk(mon_cnt == int'(v.w) * int'(v.h), "R3 pixel count over lines on selected hsync edge",
          mon_cnt, int'(v.w) * int'(v.h));
      chk(frm_width == v.w, "R4 active window width after blanking", frm_width, v.w);
      if (v.mode == 2'd3)
        chk(mon_data_err == 0, "R6 luma/chroma lanes and phase", fd_act, fd_exp);
      else
        chk(mon_data_err == 0, "R5 grayscale masking", fd_act, fd_exp);
      chk(mon_flag_err == 0, "R7 sof/sol/eol markers", ff_act, ff_exp);
      chk(frm_height == v.h, "R8 measured height", frm_height, v.h);
      chk(frm_dim_err == v.err, "R9 dimension error flag", frm_dim_err, v.err);
      chk(mon_data_err == 0 && mon_flag_err == 0, "R10 field/data-enable toggling ignored",
          mon_data_err + mon_flag_err, 0);
    end

    // directed: hsync pulses before any vsync give no pixels (R2)
    v = VECS[0];
    reset_cfg(v);
    for (int l = 0; l < 3; l++) send_line(l, v);
    vid_hsync = ~v.hsf; tick(); vid_hsync = v.hsf;
    repeat (4) tick();
    chk(mon_cnt == 0, "R2 no pixels before first frame", mon_cnt, 0);
    chk(mon_done == 0, "R2 no frame closed without vsync", mon_done, 0);

    // directed: reset in mid-line after measured frames (R1)
    v = VECS[2];
    reset_cfg(v);
    vs_pulse(v.vsf);
    for (int l = 0; l < 8; l++) send_line(l, v);
    vs_pulse(v.vsf);
    send_line(0, v);
    vid_hsync = ~v.hsf; tick(); vid_hsync = v.hsf;
    for (int c = 0; c < 5; c++) begin vid_data = raw_of(1, c); tick(); end
    chk(frm_width == 13'd24, "R8 width before reset test", frm_width, 24);
    rst = 1'b1;
    tick();
    chk({pix_valid, pix_sof, pix_sol, pix_eol} == 4'b0, "R1 markers in reset",
        {pix_valid, pix_sof, pix_sol, pix_eol}, 0);
    chk(pix_gray == 0 && pix_luma == 0 && pix_chroma == 0 && !pix_cr, "R1 data in reset",
        pix_gray, 0);
    chk(frm_width == 0 && frm_height == 0, "R1 measurements in reset",
        {frm_width, frm_height}, 0);
    chk(!frm_dim_err && !frm_done, "R1 frame status in reset", {frm_dim_err, frm_done}, 0);
    rst = 1'b0;
    tick();
    chk(!pix_valid && frm_width == 0, "R1 outputs clear after release", {pix_valid, frm_width}, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: run did not complete actual=%0d expected=%0d", 190000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule